// File: doc/BRIEF.md
# Per-Lane Read-Gate Vernier Edge Finder

This block tunes the sub-clock part of the read-gate delay in a DDR2 read path. A start pulse loads the coarse gate delay with the higher of its two passing clock values. The block then runs a strobe self-test sweep. The sweep visits every rank and every one of the 18 byte lanes. For each lane it raises an 8-bit vernier from zero, one step per trial, until a trial fails. The last passing value is the edge of the read preamble for that lane and rank.

Once every lane of every rank has been measured, the block averages the recorded edges into eight shared group values. Each value covers a group of two or three adjacent lanes, taken over all ranks. The block then lowers the coarse delay by exactly one clock, which places the gate in the centre of the preamble, and pulses done. The trials themselves (setting the delay line, issuing the read and checking the strobe pattern) happen outside the block, through a request/result port.

Top module: `vernier_edge_finder`

## Requirements
- R1: After reset, coarseOut, groupVernFlat, satFlag, done and trialReq are all zero.
- R2: A start pulse accepted while idle loads coarseOut with coarseHiIn. That value holds from the first trial request until the commit of the group values.
- R3: Trials are requested one at a time, and trialReq is high for one cycle per trial. Rank is the outer loop (0 up to NUM_RANKS-1) and lane is the inner loop (0 to 17). Within a lane the vernier starts at 0 and increases by exactly 1 per trial.
- R4: The value recorded for a lane is the vernier of its last passing trial. A lane whose first trial (vernier 0) fails records 0. A failing trial ends that lane.
- R5: A lane that still passes at vernier 255 records 255, moves on to the next lane and sets satFlag. satFlag stays set until the next accepted start clears it.
- R6: The group value is the truncated integer quotient of the sum of the recorded values of the group's lanes over all ranks, divided by lane count times NUM_RANKS. The group of lane L is L/2 for lanes 0–7, 4+(L-8)/2 for lanes 8–15, group 2 for lane 16 and group 6 for lane 17. Group g occupies groupVernFlat[8g+7:8g].
- R7: The group outputs keep their previous values during the whole sweep. They change only in the single commit, one cycle before done.
- R8: One cycle after the commit, coarseOut has dropped by exactly 1 and done is high for exactly one cycle. The group values are already in place when done is high.
- R9: A start pulse during a sweep is ignored. The sweep, its coarse value and its results are those of the start that began it.
- R10: trialPass is taken into account only in a cycle where trialAck is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration sweep (ignored while busy) |
| coarseHiIn | input | CRS_W | Higher of the two passing coarse delay values |
| coarseOut | output | CRS_W | Coarse read-gate delay to program |
| done | output | 1 | One-cycle pulse when the sweep has finished |
| trialReq | output | 1 | One-cycle request for a strobe self-test trial |
| trialRank | output | RANK_W | Rank under test |
| trialLane | output | 5 | Byte lane under test (0–17) |
| trialVern | output | 8 | Vernier setting for the trial |
| trialAck | input | 1 | Result of the outstanding trial is valid |
| trialPass | input | 1 | Trial found the strobe pattern (valid with trialAck) |
| groupVernFlat | output | 64 | Eight 8-bit group vernier values, group g at bits 8g+7:8g |
| satFlag | output | 1 | Some lane passed at the top vernier value |

## Verification
The checker assumes the responder gives exactly one trialAck per trialReq, at least one cycle after the request. It also assumes no acknowledge arrives while no trial is outstanding. The bench responder keeps to this: it holds a single pending trial, replies after 1 to 3 random cycles, and drives random junk on trialPass only while trialAck is low. Edges per lane come from $urandom over a small range, mixed with directed lanes that fail at vernier 0 or saturate at 255. Coarse inputs are kept at 1 or above so that the final drop does not wrap.

// File: rtl/vef_pkg.sv
package vef_pkg;
  localparam int VERN_W     = 8;
  localparam int NUM_LANES  = 18;
  localparam int NUM_GROUPS = 8;
  localparam int LANE_W     = $clog2(NUM_LANES);
  localparam int GRP_W      = $clog2(NUM_GROUPS);
  localparam logic [VERN_W-1:0] VERN_MAX = '1;

  typedef struct packed {
    logic              loadCoarse;
    logic              clearAcc;
    logic              record;
    logic [LANE_W-1:0] recLane;
    logic [VERN_W-1:0] recVal;
    logic              setSat;
    logic              commit;
    logic              dropCoarse;
  } vefStrobes_t;

  // Lane to shared vernier group: pairs of data lanes, ECC lane joins the middle-upper pair of its half.
  function automatic logic [GRP_W-1:0] groupOf(input logic [LANE_W-1:0] lane);
    logic [GRP_W-1:0] g;
    if (lane == LANE_W'(16))      g = GRP_W'(2);
    else if (lane == LANE_W'(17)) g = GRP_W'(6);
    else                          g = GRP_W'(lane >> 1);
    return g;
  endfunction

  function automatic int lanesIn(input int g);
    return (g == 2 || g == 6) ? 3 : 2;
  endfunction
endpackage

// File: rtl/vef_ctrl.sv
module vef_ctrl
  import vef_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              trialAck,
  input  logic              trialPass,
  output logic              trialReq,
  output logic [RANK_W-1:0] trialRank,
  output logic [LANE_W-1:0] trialLane,
  output logic [VERN_W-1:0] trialVern,
  output logic              done,
  output vefStrobes_t       strb
);
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_COMMIT, S_DROP} state_t;

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_RANKS - 1);

  state_t            state;
  logic [RANK_W-1:0] rankIdx;
  logic [LANE_W-1:0] laneIdx;
  logic [VERN_W-1:0] vernIdx;
  logic              doneR;
  logic              laneEnd;
  logic              stepUp;

  assign trialReq  = (state == S_ISSUE);
  assign trialRank = rankIdx;
  assign trialLane = laneIdx;
  assign trialVern = vernIdx;
  assign done      = doneR;

  assign stepUp  = (state == S_WAIT) && trialAck && trialPass && (vernIdx != VERN_MAX);
  assign laneEnd = (state == S_WAIT) && trialAck && !stepUp;

  always_comb begin
    strb            = '0;
    strb.loadCoarse = (state == S_IDLE) && start;
    strb.clearAcc   = (state == S_IDLE) && start;
    strb.record     = laneEnd;
    strb.recLane    = laneIdx;
    strb.setSat     = laneEnd && trialPass;
    if (trialPass)             strb.recVal = VERN_MAX;
    else if (vernIdx == '0)    strb.recVal = '0;
    else                       strb.recVal = vernIdx - VERN_W'(1);
    strb.commit     = (state == S_COMMIT);
    strb.dropCoarse = (state == S_DROP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      rankIdx <= '0;
      laneIdx <= '0;
      vernIdx <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= (state == S_DROP);
      unique case (state)
        S_IDLE: if (start) begin
          rankIdx <= '0;
          laneIdx <= '0;
          vernIdx <= '0;
          state   <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (stepUp) begin
            vernIdx <= vernIdx + VERN_W'(1);
            state   <= S_ISSUE;
          end else if (laneEnd) begin
            vernIdx <= '0;
            if (laneIdx == LAST_LANE) begin
              laneIdx <= '0;
              if (rankIdx == LAST_RANK) state <= S_COMMIT;
              else begin
                rankIdx <= rankIdx + RANK_W'(1);
                state   <= S_ISSUE;
              end
            end else begin
              laneIdx <= laneIdx + LANE_W'(1);
              state   <= S_ISSUE;
            end
          end
        end
        S_COMMIT: state <= S_DROP;
        S_DROP:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vef_datapath.sv
module vef_datapath
  import vef_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int CRS_W     = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  vefStrobes_t                  strb,
  input  logic [CRS_W-1:0]             coarseHiIn,
  output logic [CRS_W-1:0]             coarseOut,
  output logic [NUM_GROUPS*VERN_W-1:0] groupVernFlat,
  output logic                         satFlag
);
  localparam int SUM_W = VERN_W + $clog2(3 * NUM_RANKS) + 1;

  logic [CRS_W-1:0] coarseR;
  logic             satR;
  logic [GRP_W-1:0] recGroup;

  assign recGroup  = groupOf(strb.recLane);
  assign coarseOut = coarseR;
  assign satFlag   = satR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      coarseR <= '0;
      satR    <= 1'b0;
    end else begin
      if (strb.loadCoarse)      coarseR <= coarseHiIn;
      else if (strb.dropCoarse) coarseR <= coarseR - CRS_W'(1);
      if (strb.clearAcc)        satR <= 1'b0;
      else if (strb.setSat)     satR <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int DIV = lanesIn(g) * NUM_RANKS;
    logic [SUM_W-1:0]  acc;
    logic [VERN_W-1:0] vern;
    logic [SUM_W-1:0]  quot;

    assign quot = acc / SUM_W'(DIV);
    assign groupVernFlat[g*VERN_W +: VERN_W] = vern;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        acc  <= '0;
        vern <= '0;
      end else begin
        if (strb.clearAcc)
          acc <= '0;
        else if (strb.record && recGroup == GRP_W'(g))
          acc <= acc + SUM_W'(strb.recVal);
        if (strb.commit) vern <= quot[VERN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vernier_edge_finder.sv
module vernier_edge_finder
  import vef_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int CRS_W     = 4,
  parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [CRS_W-1:0]             coarseHiIn,
  output logic [CRS_W-1:0]             coarseOut,
  output logic                         done,
  output logic                         trialReq,
  output logic [RANK_W-1:0]            trialRank,
  output logic [LANE_W-1:0]            trialLane,
  output logic [VERN_W-1:0]            trialVern,
  input  logic                         trialAck,
  input  logic                         trialPass,
  output logic [NUM_GROUPS*VERN_W-1:0] groupVernFlat,
  output logic                         satFlag
);
  vefStrobes_t strb;

  vef_ctrl #(.NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .trialAck(trialAck), .trialPass(trialPass),
    .trialReq(trialReq), .trialRank(trialRank), .trialLane(trialLane),
    .trialVern(trialVern), .done(done), .strb(strb)
  );

  vef_datapath #(.NUM_RANKS(NUM_RANKS), .CRS_W(CRS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .coarseHiIn(coarseHiIn),
    .coarseOut(coarseOut), .groupVernFlat(groupVernFlat), .satFlag(satFlag)
  );
endmodule

// File: rtl/vef_checker.sv
module vef_checker
  import vef_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int CRS_W     = 4,
  parameter int RANK_W    = 1
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [CRS_W-1:0]             coarseOut,
  input logic                         done,
  input logic                         trialReq,
  input logic [RANK_W-1:0]            trialRank,
  input logic [LANE_W-1:0]            trialLane,
  input logic [VERN_W-1:0]            trialVern,
  input logic                         trialAck,
  input logic                         trialPass,
  input logic [NUM_GROUPS*VERN_W-1:0] groupVernFlat,
  input logic                         satFlag
);
  logic              haveLast;
  logic [RANK_W-1:0] lastRank;
  logic [LANE_W-1:0] lastLane;
  logic [VERN_W-1:0] lastVern;
  logic              sameLane;

  assign sameLane = haveLast && trialLane == lastLane && trialRank == lastRank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveLast <= 1'b0;
      lastRank <= '0;
      lastLane <= '0;
      lastVern <= '0;
    end else if (trialReq) begin
      haveLast <= 1'b1;
      lastRank <= trialRank;
      lastLane <= trialLane;
      lastVern <= trialVern;
    end
  end

  assert_single_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    trialReq |=> !trialReq);

  assert_vern_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trialReq && sameLane) |-> trialVern == lastVern + VERN_W'(1));

  assert_vern_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trialReq && haveLast && !sameLane) |-> trialVern == '0);

  assert_coarse_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> coarseOut == $past(coarseOut) - CRS_W'(1));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_groups_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(groupVernFlat) |=> done);

  assert_sat_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(satFlag) |-> $past(trialAck && trialPass && trialVern == VERN_MAX));

  assert_no_req_when_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !trialReq);
endmodule

bind vernier_edge_finder vef_checker #(
  .NUM_RANKS(NUM_RANKS), .CRS_W(CRS_W), .RANK_W(RANK_W)
) u_chk (
  .clk(clk), .rstN(rstN), .coarseOut(coarseOut), .done(done),
  .trialReq(trialReq), .trialRank(trialRank), .trialLane(trialLane),
  .trialVern(trialVern), .trialAck(trialAck), .trialPass(trialPass),
  .groupVernFlat(groupVernFlat), .satFlag(satFlag)
);

// File: tb/vernier_edge_finder_tb.sv
module vernier_edge_finder_tb;
  localparam int NR    = 2;
  localparam int CW    = 4;
  localparam int RW    = 1;
  localparam int LANES = 18;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] coarseHiIn = '0;
  logic [CW-1:0] coarseOut;
  logic          done;
  logic          trialReq;
  logic [RW-1:0] trialRank;
  logic [4:0]    trialLane;
  logic [7:0]    trialVern;
  logic          trialAck = 1'b0;
  logic          trialPass = 1'b0;
  logic [63:0]   groupVernFlat;
  logic          satFlag;

  always #2 clk = ~clk;

  vernier_edge_finder #(.NUM_RANKS(NR), .CRS_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .coarseHiIn(coarseHiIn),
    .coarseOut(coarseOut), .done(done), .trialReq(trialReq),
    .trialRank(trialRank), .trialLane(trialLane), .trialVern(trialVern),
    .trialAck(trialAck), .trialPass(trialPass),
    .groupVernFlat(groupVernFlat), .satFlag(satFlag)
  );

  int edgeV [NR][LANES];   // last passing vernier, -1 = fails at 0
  int checks = 0;
  int fails  = 0;
  int orderErr, coarseErr, holdErr, trialCount;
  int expR, expL, expV;
  logic [CW-1:0] expCoarse;
  logic [63:0]   heldGroups;
  int pending = 0;
  logic pendPass = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int grpOfLane(input int l);
    if (l == 16) return 2;
    if (l == 17) return 6;
    if (l < 8)   return l / 2;
    return 4 + (l - 8) / 2;
  endfunction

  function automatic int expGroup(input int g);
    int s = 0, n = 0;
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < LANES; l++)
        if (grpOfLane(l) == g) begin
          s += (edgeV[r][l] < 0) ? 0 : edgeV[r][l];
          n++;
        end
    return s / n;
  endfunction

  function automatic int expTrials();
    int t = 0;
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < LANES; l++)
        t += (edgeV[r][l] >= 255) ? 256 : edgeV[r][l] + 2;
    return t;
  endfunction

  function automatic bit expSat();
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < LANES; l++)
        if (edgeV[r][l] >= 255) return 1'b1;
    return 1'b0;
  endfunction

  // Trial responder: one pending trial, reply after 1..3 cycles; junk on pass when no ack (R10)
  initial begin
    forever begin
      @(negedge clk);
      trialAck  = 1'b0;
      trialPass = 1'($urandom_range(0, 1));
      if (pending > 0) begin
        pending--;
        if (pending == 0) begin
          trialAck  = 1'b1;
          trialPass = pendPass;
        end
      end
      if (trialReq) begin
        int r, l, v;
        r = int'(trialRank); l = int'(trialLane); v = int'(trialVern);
        trialCount++;
        if (r != expR || l != expL || v != expV) orderErr++;
        if (coarseOut != expCoarse) coarseErr++;
        if (groupVernFlat != heldGroups) holdErr++;
        pendPass = (r < NR && l < LANES) ? (v <= edgeV[r][l]) : 1'b0;
        if (pendPass && v < 255) expV++;
        else begin
          expV = 0;
          if (expL == LANES - 1) begin expL = 0; expR++; end
          else expL++;
        end
        pending = $urandom_range(1, 3);
      end
    end
  end

  task automatic runSweep(input logic [CW-1:0] hi, input bit glitch, input string tag);
    bit got = 0;
    orderErr = 0; coarseErr = 0; holdErr = 0; trialCount = 0;
    expR = 0; expL = 0; expV = 0;
    expCoarse  = hi;
    heldGroups = groupVernFlat;
    @(negedge clk);
    start = 1'b1; coarseHiIn = hi;
    @(negedge clk);
    start = 1'b0;
    if (glitch) begin
      repeat (15) @(negedge clk);
      start = 1'b1; coarseHiIn = hi + CW'(3);
      @(negedge clk);
      start = 1'b0; coarseHiIn = '0;
    end
    for (int c = 0; c < 60000; c++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
    check(got, "R8", {tag, " done seen"}, got, 1);
    check(coarseOut == hi - CW'(1), "R8", {tag, " coarse dropped"}, coarseOut, hi - CW'(1));
    for (int g = 0; g < 8; g++)
      check(groupVernFlat[g*8 +: 8] == 8'(expGroup(g)), "R6", {tag, " group value"},
            groupVernFlat[g*8 +: 8], expGroup(g));
    check(orderErr == 0, "R3", {tag, " trial order errors"}, orderErr, 0);
    check(trialCount == expTrials(), "R4", {tag, " trial count"}, trialCount, expTrials());
    check(satFlag == expSat(), "R5", {tag, " saturation flag"}, satFlag, expSat());
    check(coarseErr == 0, "R2", {tag, " coarse during sweep"}, coarseErr, 0);
    check(holdErr == 0, "R7", {tag, " groups held during sweep"}, holdErr, 0);
    @(negedge clk);
    check(done == 1'b0, "R8", {tag, " done one cycle"}, done, 0);
    check(trialReq == 1'b0 && trialCount == expTrials(), "R9", {tag, " no extra trials"},
          trialCount, expTrials());
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < LANES; l++) edgeV[r][l] = -1;
    repeat (3) @(negedge clk);
    check(coarseOut == '0 && done == 1'b0 && trialReq == 1'b0, "R1", "reset outputs",
          {coarseOut, done, trialReq}, 0);
    check(groupVernFlat == '0 && satFlag == 1'b0, "R1", "reset groups/sat",
          groupVernFlat, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: every trial at vernier 0 fails -> records 0 (R4)
    runSweep(4'd9, 1'b0, "allfail");

    // Random small edges
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < LANES; l++) edgeV[r][l] = $urandom_range(0, 40) - 1;
    runSweep(4'd5, 1'b0, "rand1");

    // Saturation on two lanes plus mid edges, with ignored start glitch (R9)
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < LANES; l++) edgeV[r][l] = $urandom_range(10, 30);
    edgeV[0][16] = 255;
    edgeV[1][3]  = 255;
    runSweep(4'd12, 1'b1, "sat");

    // sat clears on next start; random spread again (R5, R10)
    for (int r = 0; r < NR; r++)
      for (int l = 0; l < LANES; l++) edgeV[r][l] = $urandom_range(0, 60);
    runSweep(4'd1, 1'b0, "rand2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule